// File: doc/BRIEF.md
# Rectangle-Corner Kernel Accumulation Engine

This engine builds a small aerial-image intensity tile from a list of layout rectangles and a bank of convolution kernels that sit in on-chip storage. A rectangle is given by two opposite corners. The engine works through one kernel at a time. For that kernel it steps over every rectangle and then over that rectangle's four corners. At each corner it sweeps the whole tile and adds a signed, shifted copy of the kernel into a partial-sum image. When every rectangle has been applied, the engine squares each partial-sum pixel, multiplies it by the weight of that kernel, and adds the result into the intensity tile.

Software first writes the kernel samples, the kernel weights and the rectangle corners through simple write ports. It then pulses `start` together with the number of rectangles to use. It waits for `done` and reads the tile back one pixel at a time through a combinational read port. Pixel index p stands for x = p mod IMG and y = p / IMG. A kernel sample k(dx,dy) of kernel k is stored at address k·KS·KS + dy·KS + dx.

Top module: `ckae_top`

## Requirements
- R1: Corners are applied in the order (x1,y1) with sign +, (x2,y1) with sign −, (x2,y2) with sign +, (x1,y2) with sign −. Pixel (x,y) receives sign·k(x−cx, y−cy) from corner (cx,cy).
- R2: A shifted sample whose offset dx = x−cx or dy = y−cy lies outside 0..KS−1 adds zero.
- R3: Partial sums carry enough guard bits that the sum of 4·MAX_RECT terms can never wrap, including sign-flipped most-negative samples.
- R4: The partial-sum image is cleared at the start of every kernel pass. The intensity tile is cleared when `start` is accepted, so results from earlier runs do not carry over.
- R5: Intensity at a pixel is the sum over all K kernels of weight_k · P_k², where P_k is that kernel's partial sum. A kernel whose weight is 0 has no effect.
- R6: Each per-kernel term and the running intensity saturate at 2^IW − 1.
- R7: One pixel is updated per cycle. A run holds `busy` for exactly K·(1 + 4·nrect·IMG² + IMG²) cycles.
- R8: `done` is a one-cycle pulse, raised in the first idle cycle after the last kernel's fold pass.
- R9: After reset, `busy` and `done` are low and every intensity pixel reads 0.
- R10: A run with nrect = 0 gives an all-zero tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kld_en | input | 1 | Kernel sample write strobe |
| kld_addr | input | KAW | Kernel sample address k·KS·KS + dy·KS + dx |
| kld_data | input | KW | Signed kernel sample |
| wld_en | input | 1 | Weight write strobe |
| wld_idx | input | KB | Kernel index for the weight |
| wld_data | input | WW | Unsigned kernel weight |
| rld_en | input | 1 | Rectangle write strobe |
| rld_idx | input | RB | Rectangle slot |
| rld_x1 | input | CW | First corner x |
| rld_y1 | input | CW | First corner y |
| rld_x2 | input | CW | Opposite corner x |
| rld_y2 | input | CW | Opposite corner y |
| start | input | 1 | Begin a run (ignored while busy) |
| nrect | input | NB | Rectangles to use, 0..MAX_RECT |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_pix | input | PB | Intensity read index y·IMG + x |
| rd_val | output | IW | Intensity at rd_pix |

## Verification
The bench places rectangles that share a corner so that opposite signs cancel there. A sign or corner-order mistake would leave a large square at that point instead of zero. Kernels set to full scale, together with the largest weight, drive the intensity into saturation; a design that wraps would show small or scrambled values. Two kernels with different weights, and a repeated run, expose a missing clear of the partial sum or of the tile, which would show up as a doubled or leaked contribution. Corners close to the tile edge, an empty rectangle list and measurement of the busy length catch a bad support check, stray writes and a wrong pixel rate.

// File: rtl/ckae_pkg.sv
// Shared types for the corner kernel accumulation engine.
package ckae_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_CLR, ST_ACC, ST_FOLD} ckae_state_e;

    // Corner c (0..3): uses x2 for c=1,2; y2 for c=2,3; negative for odd c.
    function automatic logic corner_neg(input logic [1:0] c);
        return c[0];
    endfunction
    function automatic logic corner_use_x2(input logic [1:0] c);
        return c[0] ^ c[1];
    endfunction
    function automatic logic corner_use_y2(input logic [1:0] c);
        return c[1];
    endfunction
endpackage

// File: rtl/ckae_seq.sv
// Loop sequencer: kernel outermost, then rectangle, then corner, then pixel.
// After the corner sweeps it runs one fold sweep over all pixels for each kernel.
// Assumes PIX is a power of two and nrect <= MAX_RECT.
module ckae_seq
    import ckae_pkg::*;
#(
    parameter int K        = 2,
    parameter int MAX_RECT = 4,
    parameter int PIX      = 64,
    localparam int KB = (K > 1) ? $clog2(K) : 1,
    localparam int RB = (MAX_RECT > 1) ? $clog2(MAX_RECT) : 1,
    localparam int NB = $clog2(MAX_RECT + 1),
    localparam int PB = $clog2(PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NB-1:0]     nrect_in,
    output ckae_state_e       st,
    output logic [KB-1:0]     kidx,
    output logic [RB-1:0]     ridx,
    output logic [1:0]        corner,
    output logic [PB-1:0]     pix,
    output logic              clr_int,
    output logic              done
);
    logic [NB-1:0] nrect_q;
    logic          last_pix;

    // Accept a start request only when idle.
    assign clr_int  = (st == ST_IDLE) && start;
    assign last_pix = (pix == PB'(PIX - 1));

    // Step the nested loop counters and the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            kidx    <= '0;
            ridx    <= '0;
            corner  <= '0;
            pix     <= '0;
            nrect_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    nrect_q <= nrect_in;
                    kidx    <= '0;
                    st      <= ST_CLR;
                end
                ST_CLR: begin
                    ridx   <= '0;
                    corner <= '0;
                    pix    <= '0;
                    st     <= (nrect_q == '0) ? ST_FOLD : ST_ACC;
                end
                ST_ACC: begin
                    pix <= pix + 1'b1;
                    if (last_pix) begin
                        corner <= corner + 1'b1;
                        if (corner == 2'd3) begin
                            ridx <= ridx + 1'b1;
                            if (NB'(ridx) + NB'(1) == nrect_q) st <= ST_FOLD;
                        end
                    end
                end
                ST_FOLD: begin
                    pix <= pix + 1'b1;
                    if (last_pix) begin
                        if (kidx == KB'(K - 1)) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            kidx <= kidx + 1'b1;
                            st   <= ST_CLR;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7: every sweep cycle moves to the next pixel.
    assert_pixel_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACC || st == ST_FOLD) |=> (pix == $past(pix) + 1'b1));
endmodule

// File: rtl/ckae_tap.sv
// Kernel tap locator: for the current pixel and corner it forms the shifted
// kernel offset, flags offsets outside the KS x KS support, and builds the
// kernel memory address. Assumes KS <= IMG.
module ckae_tap
    import ckae_pkg::*;
#(
    parameter int IMG = 8,
    parameter int KS  = 4,
    parameter int K   = 2,
    localparam int CW  = $clog2(IMG),
    localparam int PB  = 2 * CW,
    localparam int KB  = (K > 1) ? $clog2(K) : 1,
    localparam int KAW = $clog2(K * KS * KS)
) (
    input  logic [PB-1:0]  pix,
    input  logic [1:0]     corner,
    input  logic [KB-1:0]  kidx,
    input  logic [CW-1:0]  x1, y1, x2, y2,
    output logic           tap_ok,
    output logic           tap_neg,
    output logic [KAW-1:0] tap_addr
);
    localparam logic [CW:0] KS_L = (CW + 1)'(KS);
    logic [CW-1:0]   cx, cy;
    logic signed [CW:0] dx, dy;

    // Pick the corner, form the offset and check it against the support.
    always_comb begin
        cx      = corner_use_x2(corner) ? x2 : x1;
        cy      = corner_use_y2(corner) ? y2 : y1;
        dx      = $signed({1'b0, pix[CW-1:0]}) - $signed({1'b0, cx});
        dy      = $signed({1'b0, pix[PB-1:CW]}) - $signed({1'b0, cy});
        tap_ok  = !dx[CW] && !dy[CW] && ($unsigned(dx) < KS_L) && ($unsigned(dy) < KS_L);
        tap_neg = corner_neg(corner);
        tap_addr = KAW'(kidx) * KAW'(KS * KS) + KAW'($unsigned(dy)) * KAW'(KS)
                 + KAW'($unsigned(dx));
    end
endmodule

// File: rtl/ckae_fold.sv
// Fold stage: squares a signed partial sum, scales it by the kernel weight,
// saturates it, and adds it into an intensity pixel with saturation.
module ckae_fold #(
    parameter int PW = 13,
    parameter int WW = 8,
    parameter int IW = 16,
    localparam int QW = 2 * PW + WW
) (
    input  logic signed [PW-1:0] psum,
    input  logic [WW-1:0]        wt,
    input  logic [IW-1:0]        old_val,
    output logic [IW-1:0]        new_val
);
    localparam logic [IW-1:0] SAT = '1;
    logic [PW-1:0]   mag;
    logic [QW-1:0]   prod;
    logic [IW-1:0]   term;
    logic [IW:0]     sum;

    // Magnitude squared times weight, clamped, then a clamped add.
    always_comb begin
        mag     = psum[PW-1] ? $unsigned(-psum) : $unsigned(psum);
        prod    = QW'(mag) * QW'(mag) * QW'(wt);
        term    = (prod > QW'(SAT)) ? SAT : prod[IW-1:0];
        sum     = {1'b0, old_val} + {1'b0, term};
        new_val = sum[IW] ? SAT : sum[IW-1:0];
    end

    // R5/R6: adding a non-negative term never lowers the intensity.
    always_comb begin
        assert_fold_grows_R6: assert (new_val >= old_val);
    end
endmodule

// File: rtl/ckae_top.sv
// Corner kernel accumulation engine top. It holds the kernel, weight,
// rectangle, partial-sum and intensity storage, and ties the sequencer,
// the tap locator and the fold stage together. The write ports may be used
// at any time; writing during a run changes that run's result.
module ckae_top
    import ckae_pkg::*;
#(
    parameter int IMG      = 8,
    parameter int KS       = 4,
    parameter int K        = 2,
    parameter int MAX_RECT = 4,
    parameter int KW       = 8,
    parameter int WW       = 8,
    parameter int IW       = 16,
    localparam int CW  = $clog2(IMG),
    localparam int PIX = IMG * IMG,
    localparam int PB  = 2 * CW,
    localparam int KN  = K * KS * KS,
    localparam int KAW = $clog2(KN),
    localparam int KB  = (K > 1) ? $clog2(K) : 1,
    localparam int RB  = (MAX_RECT > 1) ? $clog2(MAX_RECT) : 1,
    localparam int NB  = $clog2(MAX_RECT + 1),
    localparam int PW  = KW + $clog2(4 * MAX_RECT) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kld_en,
    input  logic [KAW-1:0]       kld_addr,
    input  logic signed [KW-1:0] kld_data,
    input  logic                 wld_en,
    input  logic [KB-1:0]        wld_idx,
    input  logic [WW-1:0]        wld_data,
    input  logic                 rld_en,
    input  logic [RB-1:0]        rld_idx,
    input  logic [CW-1:0]        rld_x1,
    input  logic [CW-1:0]        rld_y1,
    input  logic [CW-1:0]        rld_x2,
    input  logic [CW-1:0]        rld_y2,
    input  logic                 start,
    input  logic [NB-1:0]        nrect,
    output logic                 busy,
    output logic                 done,
    input  logic [PB-1:0]        rd_pix,
    output logic [IW-1:0]        rd_val
);
    logic signed [KW-1:0] kram [KN];
    logic [WW-1:0]        wram [K];
    logic [CW-1:0]        rx1 [MAX_RECT], ry1 [MAX_RECT], rx2 [MAX_RECT], ry2 [MAX_RECT];
    logic signed [PW-1:0] psum_q [PIX];
    logic [IW-1:0]        inten_q [PIX];

    ckae_state_e    st;
    logic [KB-1:0]  kidx;
    logic [RB-1:0]  ridx;
    logic [1:0]     corner;
    logic [PB-1:0]  pix;
    logic           clr_int;
    logic           tap_ok, tap_neg;
    logic [KAW-1:0] tap_addr;
    logic signed [PW-1:0] tap_term;
    logic [IW-1:0]  fold_val;

    ckae_seq #(.K(K), .MAX_RECT(MAX_RECT), .PIX(PIX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .nrect_in(nrect),
        .st(st), .kidx(kidx), .ridx(ridx), .corner(corner), .pix(pix),
        .clr_int(clr_int), .done(done)
    );

    ckae_tap #(.IMG(IMG), .KS(KS), .K(K)) u_tap (
        .pix(pix), .corner(corner), .kidx(kidx),
        .x1(rx1[ridx]), .y1(ry1[ridx]), .x2(rx2[ridx]), .y2(ry2[ridx]),
        .tap_ok(tap_ok), .tap_neg(tap_neg), .tap_addr(tap_addr)
    );

    ckae_fold #(.PW(PW), .WW(WW), .IW(IW)) u_fold (
        .psum(psum_q[pix]), .wt(wram[kidx]), .old_val(inten_q[pix]), .new_val(fold_val)
    );

    assign busy   = (st != ST_IDLE);
    assign rd_val = inten_q[rd_pix];

    // Signed, support-masked kernel term for the current corner.
    always_comb begin
        tap_term = tap_ok ? PW'(kram[tap_addr]) : '0;
        if (tap_neg) tap_term = -tap_term;
    end

    // Load ports for kernel samples, weights and rectangle corners.
    always_ff @(posedge clk) begin
        if (kld_en) kram[kld_addr] <= kld_data;
        if (wld_en) wram[wld_idx] <= wld_data;
        if (rld_en) begin
            rx1[rld_idx] <= rld_x1;
            ry1[rld_idx] <= rld_y1;
            rx2[rld_idx] <= rld_x2;
            ry2[rld_idx] <= rld_y2;
        end
    end

    // Partial sums: cleared per kernel pass, one pixel updated per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_CLR) begin
            for (int i = 0; i < PIX; i++) psum_q[i] <= '0;
        end else if (st == ST_ACC) begin
            psum_q[pix] <= psum_q[pix] + tap_term;
        end
    end

    // Intensity tile: cleared on an accepted start, folded one pixel per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_int) begin
            for (int i = 0; i < PIX; i++) inten_q[i] <= '0;
        end else if (st == ST_FOLD) begin
            inten_q[pix] <= fold_val;
        end
    end

    // R3: the guard bits keep every accumulation step free of wrap.
    logic signed [PW:0] wide_sum;
    always_comb begin
        wide_sum = {psum_q[pix][PW-1], psum_q[pix]} + {tap_term[PW-1], tap_term};
        if (rst_n && st == ST_ACC) begin
            assert_no_overflow_R3: assert (wide_sum[PW] == wide_sum[PW-1]);
        end
    end

    // R8: done lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done follows the last fold sweep.
    assert_done_after_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == ST_FOLD && !busy));
endmodule

// File: tb/ckae_top_tb.sv
module ckae_top_tb;
    localparam int IMG = 8, KS = 4, K = 2, MAX_RECT = 4, KW = 8, WW = 8, IW = 16;
    localparam int PIX = IMG * IMG;
    localparam int SAT = (1 << IW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kld_en = 0, wld_en = 0, rld_en = 0, start = 0;
    logic [4:0] kld_addr = '0;
    logic signed [7:0] kld_data = '0;
    logic wld_idx = 0;
    logic [7:0] wld_data = '0;
    logic [1:0] rld_idx = '0;
    logic [2:0] rld_x1 = '0, rld_y1 = '0, rld_x2 = '0, rld_y2 = '0;
    logic [2:0] nrect = '0;
    logic busy, done;
    logic [5:0] rd_pix = '0;
    logic [15:0] rd_val;

    int errors = 0, checks = 0;
    int kern [K][KS*KS];
    int wt [K];
    int rc [MAX_RECT][4];

    always #2.5 clk = ~clk;

    ckae_top u_dut (
        .clk(clk), .rst_n(rst_n), .kld_en(kld_en), .kld_addr(kld_addr), .kld_data(kld_data),
        .wld_en(wld_en), .wld_idx(wld_idx), .wld_data(wld_data),
        .rld_en(rld_en), .rld_idx(rld_idx), .rld_x1(rld_x1), .rld_y1(rld_y1),
        .rld_x2(rld_x2), .rld_y2(rld_y2), .start(start), .nrect(nrect),
        .busy(busy), .done(done), .rd_pix(rd_pix), .rd_val(rd_val)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference intensity at pixel p from the requirement formulas.
    function automatic int ref_pix(input int p, input int nr);
        int x = p % IMG, y = p / IMG;
        longint acc = 0;
        for (int k = 0; k < K; k++) begin
            longint s = 0, t;
            for (int r = 0; r < nr; r++) begin
                for (int c = 0; c < 4; c++) begin
                    int cx = (c == 1 || c == 2) ? rc[r][2] : rc[r][0];
                    int cy = (c >= 2) ? rc[r][3] : rc[r][1];
                    int dx = x - cx, dy = y - cy;
                    if (dx >= 0 && dx < KS && dy >= 0 && dy < KS)
                        s += ((c % 2) ? -1 : 1) * kern[k][dy*KS + dx];
                end
            end
            t = s * s * wt[k];
            if (t > SAT) t = SAT;
            acc += t;
            if (acc > SAT) acc = SAT;
        end
        return int'(acc);
    endfunction

    task automatic load_all();
        for (int k = 0; k < K; k++) begin
            for (int i = 0; i < KS*KS; i++) begin
                @(negedge clk);
                kld_en = 1; kld_addr = 5'(k*KS*KS + i); kld_data = 8'(kern[k][i]);
            end
            @(negedge clk);
            kld_en = 0; wld_en = 1; wld_idx = 1'(k); wld_data = 8'(wt[k]);
        end
        for (int r = 0; r < MAX_RECT; r++) begin
            @(negedge clk);
            wld_en = 0; rld_en = 1; rld_idx = 2'(r);
            rld_x1 = 3'(rc[r][0]); rld_y1 = 3'(rc[r][1]);
            rld_x2 = 3'(rc[r][2]); rld_y2 = 3'(rc[r][3]);
        end
        @(negedge clk);
        kld_en = 0; wld_en = 0; rld_en = 0;
    endtask

    // Start a run, measure busy length, check done pulse and every pixel.
    task automatic run_check(input int nr, input string tag);
        int bcnt = 0;
        int mism = 0;
        @(negedge clk);
        start = 1; nrect = 3'(nr);
        @(negedge clk);
        start = 0;
        while (!done && bcnt < 5000) begin
            if (busy) bcnt++;
            @(negedge clk);
        end
        chk({"R7 busy length ", tag}, bcnt, K * (1 + 4*nr*PIX + PIX));
        chk({"R8 done/busy ", tag}, {done, busy}, 2'b10);
        @(negedge clk);
        chk({"R8 done one cycle ", tag}, done, 0);
        for (int p = 0; p < PIX; p++) begin
            rd_pix = 6'(p);
            #0.5;
            if (rd_val != 16'(ref_pix(p, nr))) begin
                mism++;
                if (mism <= 3) chk({"R5 pixel ", tag}, rd_val, ref_pix(p, nr));
            end
        end
        chk({"R5 pixel mismatches ", tag}, mism, 0);
    endtask

    task automatic clear_model();
        for (int k = 0; k < K; k++) begin
            wt[k] = 0;
            for (int i = 0; i < KS*KS; i++) kern[k][i] = 0;
        end
        for (int r = 0; r < MAX_RECT; r++) for (int j = 0; j < 4; j++) rc[r][j] = 0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5501));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy after reset", busy, 0);
        chk("R9 done after reset", done, 0);
        rd_pix = 6'd9; #0.5;
        chk("R9 intensity after reset", rd_val, 0);

        // R1: shared corner at (3,1) must cancel; lone corners give 100.
        clear_model();
        kern[0][0] = 10; wt[0] = 1;
        rc[0] = '{1, 1, 3, 3}; rc[1] = '{3, 1, 5, 3};
        load_all();
        run_check(2, "R1 shared corner");
        rd_pix = 6'(1*IMG + 3); #0.5;
        chk("R1 cancel at shared corner", rd_val, 0);
        rd_pix = 6'(1*IMG + 1); #0.5;
        chk("R1 lone corner", rd_val, 100);

        // R2: corners near the tile edge with a full kernel.
        clear_model();
        for (int i = 0; i < KS*KS; i++) kern[0][i] = i + 1;
        wt[0] = 1;
        rc[0] = '{6, 6, 7, 7};
        load_all();
        run_check(1, "R2 edge support");
        rd_pix = 6'(5*IMG + 5); #0.5;
        chk("R2 outside support", rd_val, 0);

        // R6 and R3: full-scale kernels, largest weight, overlapping rectangles.
        clear_model();
        for (int i = 0; i < KS*KS; i++) begin kern[0][i] = -128; kern[1][i] = 127; end
        wt[0] = 255; wt[1] = 255;
        rc[0] = '{0, 0, 7, 7}; rc[1] = '{0, 0, 7, 7}; rc[2] = '{0, 0, 7, 7}; rc[3] = '{0, 0, 7, 7};
        load_all();
        run_check(4, "R6 saturation");
        rd_pix = 6'd0; #0.5;
        chk("R6 saturated pixel", rd_val, SAT);

        // R10: empty rectangle list.
        run_check(0, "R10 empty list");

        // R5: zero weight on kernel 1 has no effect; R4 rerun does not accumulate.
        clear_model();
        for (int k = 0; k < K; k++)
            for (int i = 0; i < KS*KS; i++) kern[k][i] = int'($urandom_range(0, 60)) - 30;
        wt[0] = 3; wt[1] = 0;
        rc[0] = '{2, 2, 5, 4};
        load_all();
        run_check(1, "R5 zero weight");
        run_check(1, "R4 rerun clears tile");

        // Random trials: R1, R2, R4 (per-kernel clear), R5, R6.
        for (int t = 0; t < 8; t++) begin
            int nr;
            for (int k = 0; k < K; k++) begin
                wt[k] = int'($urandom_range(0, 255));
                for (int i = 0; i < KS*KS; i++) kern[k][i] = int'($urandom_range(0, 255)) - 128;
            end
            for (int r = 0; r < MAX_RECT; r++)
                for (int j = 0; j < 4; j++) rc[r][j] = int'($urandom_range(0, IMG - 1));
            nr = int'($urandom_range(1, MAX_RECT));
            load_all();
            run_check(nr, $sformatf("R4 random %0d", t));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule